// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation descriptors from a two-level table kept in ordinary memory. A requester hands over one virtual address at a time. The walker reads the first-level descriptor, which is selected by the top twelve address bits. It then does one of three things: it finishes at once for a 1 MB section, it fails the walk, or it reads a second-level descriptor to resolve a 4 KB page.

The result holds the physical address, a two-bit access-permission field, an execute-never flag and a two-bit cause code. It stays on the outputs until the requester acknowledges it. The walker has no translation cache. It checks no domains and writes nothing back to the tables. Descriptors with a 64 KB large-page encoding are rejected with their own cause code and are never translated.

Memory is reached through a single read port. The walker holds `memReq` high with a word address until memory answers with one `memValid` cycle carrying the descriptor. The table base input must stay stable while a walk is in progress.

Top module: `pgwalk_top`

## Requirements
- R1: After reset `reqReady` is 1, `rspValid` is 0 and `memReq` is 0.
- R2: The first fetch of a walk goes to the word address {tblBase[31:14], va[31:20], 2'b00}, and memory addresses are always word aligned.
- R3: A first-level descriptor whose bits [1:0] are 2'b10 ends the walk after one fetch. The result is physical address {desc[31:20], va[19:0]}, execute-never = desc[4], access = desc[11:10] and cause 0.
- R4: A first-level descriptor with bits [1:0] = 2'b01 starts a second fetch at {desc[31:10], va[19:12], 2'b00}. Descriptor bits [9:2] are ignored.
- R5: A second-level descriptor with bits [1:0] of 2'b10 or 2'b11 yields physical address {desc[31:12], va[11:0]}, access = desc[5:4] and cause 0. Execute-never is 1 only for 2'b11.
- R6: A first-level descriptor with bits [1:0] of 2'b00 or 2'b11 gives cause 1 after a single fetch.
- R7: A second-level descriptor with bits [1:0] = 2'b00 gives cause 2.
- R8: A second-level descriptor with bits [1:0] = 2'b01 (64 KB page) gives cause 3.
- R9: Any result with a nonzero cause has physical address 0, execute-never 0 and access 0.
- R10: `rspValid` and the result stay constant until a cycle in which `rspAck` is 1. `reqReady` is 0 from acceptance until the cycle after the acknowledge, and `reqValid` has no effect during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| tblBase | input | 32 | First-level table base; bits [31:14] are used |
| reqValid | input | 1 | Translation request present |
| reqAddr | input | 32 | Virtual address to translate |
| reqReady | output | 1 | Walker idle and able to accept a request |
| memReq | output | 1 | Descriptor read outstanding |
| memAddr | output | 32 | Word address of the descriptor |
| memValid | input | 1 | Descriptor data present this cycle |
| memData | input | 32 | Descriptor word |
| rspValid | output | 1 | Result available |
| rspPhys | output | 32 | Translated physical address |
| rspXn | output | 1 | Execute-never flag |
| rspAccess | output | 2 | Access-permission field of the descriptor |
| rspFault | output | 2 | Cause: 0 none, 1 first-level fault, 2 second-level fault, 3 large page |
| rspAck | input | 1 | Result consumed |

## Verification
The bench sweeps all 4096 first-level indices under one table base and 512 indices under a second base. The table contents are arranged so that every first-level type, and every second-level type behind a table pointer, appears many times. Junk bits in descriptor fields that must be ignored reveal any masking or bit-slice mistake. Comparing fetch count and fetch addresses separates one-fetch outcomes from two-fetch outcomes. Memory latencies from zero to two cycles, held results left unacknowledged and competing requests raised during a walk show that the handshake timing and the held result do not depend on when the answer arrives.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_FETCH_L1 = 2'd1,
    ST_FETCH_L2 = 2'd2,
    ST_DONE     = 2'd3
  } walkState_t;

  localparam logic [1:0] CAUSE_NONE  = 2'd0;
  localparam logic [1:0] CAUSE_L1    = 2'd1;
  localparam logic [1:0] CAUSE_L2    = 2'd2;
  localparam logic [1:0] CAUSE_LARGE = 2'd3;

  localparam logic [1:0] L1_FAULT   = 2'b00;
  localparam logic [1:0] L1_TABLE   = 2'b01;
  localparam logic [1:0] L1_SECTION = 2'b10;

  localparam logic [1:0] L2_FAULT   = 2'b00;
  localparam logic [1:0] L2_LARGE   = 2'b01;

  typedef struct packed {
    logic       capVa;
    logic       capL1;
    logic       finSection;
    logic       finPage;
    logic       finFault;
    logic [1:0] cause;
    logic       selL2;
  } walkCtl_t;

endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       memValid,
  input  logic [1:0] memType,
  input  logic       rspAck,
  output logic       reqReady,
  output logic       memReq,
  output logic       rspValid,
  output walkCtl_t   ctl
);

  walkState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD         = stateQ;
    ctl            = '0;
    ctl.selL2      = (stateQ == ST_FETCH_L2);
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.capVa = 1'b1;
          stateD    = ST_FETCH_L1;
        end
      end
      ST_FETCH_L1: begin
        if (memValid) begin
          if (memType == L1_SECTION) begin
            ctl.finSection = 1'b1;
            stateD         = ST_DONE;
          end else if (memType == L1_TABLE) begin
            ctl.capL1 = 1'b1;
            stateD    = ST_FETCH_L2;
          end else begin
            ctl.finFault = 1'b1;
            ctl.cause    = CAUSE_L1;
            stateD       = ST_DONE;
          end
        end
      end
      ST_FETCH_L2: begin
        if (memValid) begin
          stateD = ST_DONE;
          if (memType == L2_FAULT) begin
            ctl.finFault = 1'b1;
            ctl.cause    = CAUSE_L2;
          end else if (memType == L2_LARGE) begin
            ctl.finFault = 1'b1;
            ctl.cause    = CAUSE_LARGE;
          end else begin
            ctl.finPage = 1'b1;
          end
        end
      end
      ST_DONE: begin
        if (rspAck) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign reqReady = (stateQ == ST_IDLE);
  assign memReq   = (stateQ == ST_FETCH_L1) || (stateQ == ST_FETCH_L2);
  assign rspValid = (stateQ == ST_DONE);

  // R4: a second-level fetch is only ever entered from a first-level fetch
  assert_l2_after_l1_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_FETCH_L2 && $past(stateQ) != ST_FETCH_L2) |-> $past(stateQ) == ST_FETCH_L1);

  // R6: a first-level fault never leads to a second fetch
  assert_l1_fault_ends_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_FETCH_L1 && memValid && memType[0] == memType[1]) |=> stateQ == ST_DONE);

endmodule

// File: rtl/pgwalk_dp.sv
module pgwalk_dp
  import pgwalk_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int L1_IDX_W = 12,
  parameter int L2_IDX_W = 8,
  parameter int PAGE_W   = 12,
  parameter int XN_BIT   = 4,
  parameter int SEC_ACC_LO  = 10,
  parameter int PAGE_ACC_LO = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  walkCtl_t        ctl,
  input  logic [VA_W-1:0] tblBase,
  input  logic [VA_W-1:0] reqAddr,
  input  logic [VA_W-1:0] memData,
  output logic [VA_W-1:0] memAddr,
  output logic [VA_W-1:0] physOut,
  output logic            xnOut,
  output logic [1:0]      accOut,
  output logic [1:0]      causeOut
);

  localparam int SEC_OFF_W  = L2_IDX_W + PAGE_W;
  localparam int TTB_KEEP   = VA_W - L1_IDX_W - 2;
  localparam int L2B_KEEP   = VA_W - L2_IDX_W - 2;
  localparam int FRAME_W    = VA_W - PAGE_W;

  logic [VA_W-1:0] vaQ;
  logic [VA_W-1:0] l1DescQ;
  logic [VA_W-1:0] physQ;
  logic            xnQ;
  logic [1:0]      accQ;
  logic [1:0]      causeQ;

  logic [VA_W-1:0] l1Addr;
  logic [VA_W-1:0] l2Addr;

  assign l1Addr  = {tblBase[VA_W-1 -: TTB_KEEP], vaQ[VA_W-1 -: L1_IDX_W], 2'b00};
  assign l2Addr  = {l1DescQ[VA_W-1 -: L2B_KEEP], vaQ[PAGE_W +: L2_IDX_W], 2'b00};
  assign memAddr = ctl.selL2 ? l2Addr : l1Addr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ     <= '0;
      l1DescQ <= '0;
    end else begin
      if (ctl.capVa) vaQ     <= reqAddr;
      if (ctl.capL1) l1DescQ <= memData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      physQ  <= '0;
      xnQ    <= 1'b0;
      accQ   <= '0;
      causeQ <= CAUSE_NONE;
    end else if (ctl.finSection) begin
      physQ  <= {memData[VA_W-1 -: L1_IDX_W], vaQ[SEC_OFF_W-1:0]};
      xnQ    <= memData[XN_BIT];
      accQ   <= memData[SEC_ACC_LO +: 2];
      causeQ <= CAUSE_NONE;
    end else if (ctl.finPage) begin
      physQ  <= {memData[VA_W-1 -: FRAME_W], vaQ[PAGE_W-1:0]};
      xnQ    <= memData[0];
      accQ   <= memData[PAGE_ACC_LO +: 2];
      causeQ <= CAUSE_NONE;
    end else if (ctl.finFault) begin
      physQ  <= '0;
      xnQ    <= 1'b0;
      accQ   <= '0;
      causeQ <= ctl.cause;
    end
  end

  assign physOut  = physQ;
  assign xnOut    = xnQ;
  assign accOut   = accQ;
  assign causeOut = causeQ;

  // R5: the page offset of a small-page result comes from the captured address
  assert_page_offset_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finPage |=> physQ[PAGE_W-1:0] == $past(vaQ[PAGE_W-1:0]));

  // R3: the section offset is carried through unchanged
  assert_section_offset_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finSection |=> physQ[SEC_OFF_W-1:0] == $past(vaQ[SEC_OFF_W-1:0]));

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int L1_IDX_W = 12,
  parameter int L2_IDX_W = 8,
  parameter int PAGE_W   = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [VA_W-1:0] tblBase,
  input  logic            reqValid,
  input  logic [VA_W-1:0] reqAddr,
  output logic            reqReady,
  output logic            memReq,
  output logic [VA_W-1:0] memAddr,
  input  logic            memValid,
  input  logic [VA_W-1:0] memData,
  output logic            rspValid,
  output logic [VA_W-1:0] rspPhys,
  output logic            rspXn,
  output logic [1:0]      rspAccess,
  output logic [1:0]      rspFault,
  input  logic            rspAck
);

  walkCtl_t ctl;

  pgwalk_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .memValid (memValid),
    .memType  (memData[1:0]),
    .rspAck   (rspAck),
    .reqReady (reqReady),
    .memReq   (memReq),
    .rspValid (rspValid),
    .ctl      (ctl)
  );

  pgwalk_dp #(
    .VA_W     (VA_W),
    .L1_IDX_W (L1_IDX_W),
    .L2_IDX_W (L2_IDX_W),
    .PAGE_W   (PAGE_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .tblBase  (tblBase),
    .reqAddr  (reqAddr),
    .memData  (memData),
    .memAddr  (memAddr),
    .physOut  (rspPhys),
    .xnOut    (rspXn),
    .accOut   (rspAccess),
    .causeOut (rspFault)
  );

  // R10: result held until acknowledged
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspAck) |=> (rspValid && $stable(rspPhys) && $stable(rspFault)
                               && $stable(rspXn) && $stable(rspAccess)));

  // R10: never idle and presenting a result at once
  assert_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(reqReady && rspValid));

  // R9: faulted results carry no translation
  assert_fault_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != CAUSE_NONE) |-> (rspPhys == '0 && !rspXn && rspAccess == 2'b00));

  // R2: descriptor reads are word aligned
  assert_word_align_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[1:0] == 2'b00);

  // R2: an accepted request starts a fetch on the next cycle
  assert_accept_fetch_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> (memReq && !reqReady));

endmodule

// File: tb/pgwalk_top_tb_top.sv
`timescale 1ns/1ps
module pgwalk_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] tblBase = 32'h0001_0000;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqReady;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memValid = 1'b0;
  logic [31:0] memData = '0;
  logic        rspValid;
  logic [31:0] rspPhys;
  logic        rspXn;
  logic [1:0]  rspAccess;
  logic [1:0]  rspFault;
  logic        rspAck = 1'b0;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  int lat = 0;
  int waitCnt = 0;
  int fetchCnt = 0;
  logic [31:0] fetchAddr [0:3];

  always #2.5 clk = ~clk;

  pgwalk_top dut_i (
    .clk(clk), .rstN(rstN), .tblBase(tblBase),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqReady(reqReady),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .rspValid(rspValid), .rspPhys(rspPhys), .rspXn(rspXn),
    .rspAccess(rspAccess), .rspFault(rspFault), .rspAck(rspAck)
  );

  // Table contents computed from the address: low region holds first-level
  // entries, region from 0x0100_0000 holds second-level tables.
  function automatic logic [31:0] memModel(input logic [31:0] a);
    logic [11:0] i;
    logic [11:0] idx;
    logic [7:0]  j;
    logic [1:0]  t;
    logic [19:0] fr;
    if (a < 32'h0100_0000) begin
      i = a[13:2];
      case (i[1:0])
        2'd0:    return {i, 20'hABC0C};
        2'd1:    return 32'h0100_0000 | ({20'h0, i} << 10) | 32'h0000_02A1;
        2'd2:    return {i ^ 12'h5A5, 8'h00, i[5:4], 5'b00000, i[3], 2'b01, 2'b10};
        default: return {i, 20'h33333};
      endcase
    end else begin
      idx = a[21:10];
      j   = a[9:2];
      t   = j[1:0] + idx[1:0];
      fr  = {idx, j} ^ 20'h3C3C3;
      return {fr, 6'h2A, j[3:2], 2'b11, t};
    end
  endfunction

  always @(negedge clk) begin
    if (memValid) begin
      memValid = 1'b0;
      waitCnt  = 0;
    end else if (memReq) begin
      if (waitCnt >= lat) begin
        memValid = 1'b1;
        memData  = memModel(memAddr);
        if (fetchCnt < 4) fetchAddr[fetchCnt] = memAddr;
        fetchCnt = fetchCnt + 1;
      end else begin
        waitCnt = waitCnt + 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input bit hold, input bit interfere);
    logic [31:0] la1, la2, d1, d2, expPhys, heldPhys;
    logic [1:0]  expFault, expAcc;
    logic        expXn;
    int          expN;
    int          guard;
    string       tag;
    la1 = {tblBase[31:14], va[31:20], 2'b00};
    d1  = memModel(la1);
    la2 = '0;
    expPhys = '0; expXn = 1'b0; expAcc = 2'b00; expN = 1;
    if (d1[1:0] == 2'b10) begin
      expFault = 2'd0; expPhys = {d1[31:20], va[19:0]}; expXn = d1[4]; expAcc = d1[11:10];
      tag = "R3";
    end else if (d1[1:0] == 2'b01) begin
      expN = 2;
      la2 = {d1[31:10], va[19:12], 2'b00};
      d2  = memModel(la2);
      case (d2[1:0])
        2'b00: begin expFault = 2'd2; tag = "R7"; end
        2'b01: begin expFault = 2'd3; tag = "R8"; end
        default: begin
          expFault = 2'd0; expPhys = {d2[31:12], va[11:0]};
          expXn = d2[0]; expAcc = d2[5:4]; tag = "R5";
        end
      endcase
    end else begin
      expFault = 2'd1; tag = "R6";
    end

    fetchCnt = 0;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = va;
    @(negedge clk);
    reqValid = interfere;
    reqAddr  = ~va;
    chk("R10", "busy reqReady", {31'b0, reqReady}, 32'd0);
    guard = 0;
    while (!rspValid && guard < 40) begin
      @(negedge clk);
      guard++;
    end
    chk("R10", "rspValid", {31'b0, rspValid}, 32'd1);
    if (hold) begin
      heldPhys = rspPhys;
      @(negedge clk);
      chk("R10", "held valid", {31'b0, rspValid}, 32'd1);
      chk("R10", "held phys", rspPhys, heldPhys);
    end
    chk(tag, "cause", {30'b0, rspFault}, {30'b0, expFault});
    chk(expFault != 2'd0 ? "R9" : tag, "phys", rspPhys, expPhys);
    chk(expFault != 2'd0 ? "R9" : tag, "xn", {31'b0, rspXn}, {31'b0, expXn});
    chk(expFault != 2'd0 ? "R9" : tag, "access", {30'b0, rspAccess}, {30'b0, expAcc});
    chk(expN == 2 ? "R4" : "R6", "fetch count", fetchCnt, expN);
    chk("R2", "first fetch addr", fetchAddr[0], la1);
    if (expN == 2) chk("R4", "second fetch addr", fetchAddr[1], la2);
    reqValid = 1'b0;
    rspAck   = 1'b1;
    @(negedge clk);
    rspAck   = 1'b0;
    chk("R10", "released", {30'b0, rspValid, reqReady}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    fetchAddr[0] = '0; fetchAddr[1] = '0; fetchAddr[2] = '0; fetchAddr[3] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset outputs", {29'b0, reqReady, rspValid, memReq}, 32'b100);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "after reset", {29'b0, reqReady, rspValid, memReq}, 32'b100);

    for (int i = 0; i < 4096; i++) begin
      logic [11:0] hi;
      logic [7:0]  mid;
      logic [11:0] lo;
      hi  = i[11:0];
      mid = 8'(i * 29 + i / 4);
      lo  = 12'(i * 1237);
      lat = i % 3;
      walk({hi, mid, lo}, (i % 3) == 0, (i % 5) == 0);
    end

    tblBase = 32'h00AB_FFFF;
    for (int i = 0; i < 512; i++) begin
      logic [11:0] hi;
      hi  = 12'(i * 8 + i / 64);
      lat = (i + 1) % 3;
      walk({hi, 8'(i * 7), 12'(4095 - i * 3)}, (i % 4) == 1, (i % 7) == 0);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule